// File: doc/BRIEF.md
# Lockable Set-Associative Cache with Miss-Count Replacement

This block is a write-back, set-associative cache controller that sits between a processor port and a next-level memory. Any cache line may be pinned by a lock bit. A companion table keeps a per-block miss count, and the replacement logic consults it. A pinned line is never chosen as a victim. Among the unpinned lines of a set, the victim is the line whose block has the fewest recorded misses.

Before a real-time task runs, system software uses the configuration port in two ways. It first seeds the miss table with counts from an offline analysis. It then issues lock commands for the blocks that analysis ranked highest. A lock command fetches the block if it is absent and pins it. Pinning is capped at one quarter of all lines, so three quarters of the cache always stay available for normal replacement. If every way of a set is pinned, an access that misses in that set goes straight to memory and nothing is allocated.

Each line holds one data word, so an address is also its block number. With the defaults the cache has 4 sets of 4 ways, the miss table has 16 entries and up to 4 lines may be locked.

Top module: `lmc_cache`

## Requirements
- R1: After reset every line is invalid and unlocked. `cpu_ready` is high, and `cpu_done`, `cfg_done` and `cfg_err` are low. The first read of any address therefore fetches from memory.
- R2: A read hit returns the stored word on `cpu_rdata`. `cpu_done` pulses in the cycle after the request is accepted, and there is no memory traffic.
- R3: The set index is the address modulo the number of sets, which is the low address bits. The tag is the remaining upper bits. Blocks with different tags can reside in the same set together.
- R4: Write-back policy. A write hit updates the line and marks it dirty without any memory write. A write miss fetches the block, merges the write and marks the line dirty. Evicting a dirty line writes its old word to memory before the new block is read.
- R5: The miss table has one entry per cache line, indexed by the block number modulo the entry count. Each entry holds a valid bit, a block number and a count. A configuration write with `cfg_lock`=0 stores (`cfg_addr`, `cfg_count`) into an entry. Each processor miss, including a bypassed miss, raises the count of a matching entry, saturating at 2^CNT_W-1. If the entry holds another block, the miss replaces it with the missing block at count 1. A block without a matching entry has count 0.
- R6: The victim is the lowest-numbered invalid way if one exists. Otherwise it is the unlocked way whose block has the lowest miss count, as read before the current miss is recorded. Ties go to the least recently used way. Hits and fills make a way the most recently used.
- R7: A locked line is never evicted. It stays valid with the same tag until reset.
- R8: A lock command (`cfg_lock`=1) pins the block in place if it is present. If it is absent, the block is fetched into a victim way chosen as in R6, written back first if that victim is dirty, and installed locked and clean. Completion is one `cfg_done` pulse.
- R9: At most one quarter of the lines may be locked. A lock command for an unlocked or absent block while the cap is reached is refused with a `cfg_err` pulse and changes nothing. A lock command for an already-locked block completes with `cfg_done`.
- R10: If every way of the addressed set is locked, a processor miss bypasses the cache. A read is served from memory, a write goes straight to memory, and nothing is allocated, so the access misses again next time.
- R11: The memory request, with its address, direction and write data, stays asserted and unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, one-cycle pulse, taken when `cpu_ready` is high and `cfg_valid` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Word address (block number) |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Controller idle, able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse of a processor request |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` |
| cfg_valid | input | 1 | Configuration command pulse, taken when `cpu_ready` is high; wins over `cpu_req` |
| cfg_lock | input | 1 | 1 = lock block, 0 = write miss-table entry |
| cfg_addr | input | 10 | Block number of the command |
| cfg_count | input | 4 | Miss count for a table write |
| cfg_done | output | 1 | One-cycle completion pulse of a configuration command |
| cfg_err | output | 1 | One-cycle pulse: lock command refused |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data is valid with it |
| mem_rdata | input | 32 | Memory read data |

## Verification
Several properties are checked on every cycle: the number of locked lines never exceeds the cap, a locked line keeps its valid bit and tag from one cycle to the next, a pending memory request holds its address, direction and data, and completions are never reported as both done and refused. Which way is evicted, the miss-count ordering with its recency tie-break, the counter saturation, bypass without allocation and the delayed write-back of dirty data can only be shown through scenarios. The bench runs a behavioural model of contents, recency, miss table and memory, and compares read data and per-request memory traffic after each request.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 32;
    localparam int SETS     = 4;
    localparam int WAYS     = 4;
    localparam int CNT_W    = 4;

    localparam int SET_W    = $clog2(SETS);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int TAG_W    = ADDR_W - SET_W;
    localparam int LINES    = SETS * WAYS;
    localparam int LOCK_CAP = LINES / 4;
    localparam int LCNT_W   = $clog2(LOCK_CAP + 1);
    localparam int MT_N     = LINES;
    localparam int MT_IW    = $clog2(MT_N);

    typedef struct packed {
        logic              lock;
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] blk;
        logic [CNT_W-1:0]  cnt;
    } mt_ent_t;

    typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL, ST_BYP} st_t;
    typedef enum logic [1:0] {OP_RD, OP_WR, OP_LOCK} op_t;

    function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
        return a[SET_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:SET_W];
    endfunction
endpackage

// File: rtl/lmc_miss_table.sv
module lmc_miss_table
    import lmc_pkg::*;
#(
    parameter int N  = MT_N,
    parameter int NQ = WAYS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_blk,
    input  logic [CNT_W-1:0]            cfg_cnt,
    input  logic                        inc_en,
    input  logic [ADDR_W-1:0]           inc_blk,
    input  logic [NQ-1:0][ADDR_W-1:0]   q_blk,
    output logic [NQ-1:0][CNT_W-1:0]    q_cnt
);
    localparam int IW = $clog2(N);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    mt_ent_t tbl [N];

    logic [IW-1:0] cfg_idx, inc_idx;
    assign cfg_idx = cfg_blk[IW-1:0];
    assign inc_idx = inc_blk[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) tbl[i] <= '0;
        end else if (cfg_we) begin
            tbl[cfg_idx] <= '{vld: 1'b1, blk: cfg_blk, cnt: cfg_cnt};
        end else if (inc_en) begin
            if (tbl[inc_idx].vld && tbl[inc_idx].blk == inc_blk) begin
                if (tbl[inc_idx].cnt != CMAX)
                    tbl[inc_idx].cnt <= tbl[inc_idx].cnt + 1'b1;
            end else begin
                tbl[inc_idx] <= '{vld: 1'b1, blk: inc_blk, cnt: CNT_W'(1)};
            end
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic [IW-1:0] qi;
        assign qi = q_blk[g][IW-1:0];
        assign q_cnt[g] = (tbl[qi].vld && tbl[qi].blk == q_blk[g]) ? tbl[qi].cnt : '0;
    end
endmodule

// File: rtl/lmc_lru.sv
module lmc_lru
    import lmc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][WAY_W-1:0]  rd_age,
    input  logic                        touch_en,
    input  logic [SET_W-1:0]            touch_set,
    input  logic [WAY_W-1:0]            touch_way
);
    logic [WAYS-1:0][WAY_W-1:0] age [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age[touch_set][w] <= '0;
                else if (age[touch_set][w] < age[touch_set][touch_way])
                    age[touch_set][w] <= age[touch_set][w] + 1'b1;
            end
        end
    end

    assign rd_age = age[rd_set];
endmodule

// File: rtl/lmc_victim_sel.sv
module lmc_victim_sel
    import lmc_pkg::*;
(
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0]             lock,
    input  logic [WAYS-1:0][CNT_W-1:0]  cnt,
    input  logic [WAYS-1:0][WAY_W-1:0]  age,
    output logic                        found,
    output logic [WAY_W-1:0]            way
);
    logic             have_inv;
    logic [CNT_W-1:0] best_cnt;
    logic [WAY_W-1:0] best_age;

    always_comb begin
        found    = 1'b0;
        way      = '0;
        have_inv = 1'b0;
        best_cnt = '0;
        best_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !have_inv) begin
                have_inv = 1'b1;
                found    = 1'b1;
                way      = WAY_W'(w);
            end
        end
        if (!have_inv) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!lock[w] &&
                    (!found || cnt[w] < best_cnt ||
                     (cnt[w] == best_cnt && age[w] > best_age))) begin
                    found    = 1'b1;
                    way      = WAY_W'(w);
                    best_cnt = cnt[w];
                    best_age = age[w];
                end
            end
        end
    end
endmodule

// File: rtl/lmc_cache.sv
module lmc_cache
    import lmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cfg_valid,
    input  logic              cfg_lock,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              cfg_done,
    output logic              cfg_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    line_t             lines [SETS][WAYS];
    st_t               st;
    op_t               r_op;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [WAY_W-1:0]  r_way;
    logic [LCNT_W-1:0] lock_cnt;

    logic                        idle;
    logic [ADDR_W-1:0]           look_addr;
    logic [SET_W-1:0]            look_set, r_set;
    logic [TAG_W-1:0]            look_tag;
    logic [WAYS-1:0]             hit_vec, way_valid, way_lock;
    logic [WAYS-1:0][ADDR_W-1:0] way_blk;
    logic [WAYS-1:0][CNT_W-1:0]  way_cnt;
    logic [WAYS-1:0][WAY_W-1:0]  way_age;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic                        vic_found;
    logic [WAY_W-1:0]            vic_way;
    logic                        vic_dirty;
    logic                        cpu_take, at_cap;
    logic                        touch_en;
    logic [SET_W-1:0]            touch_set;
    logic [WAY_W-1:0]            touch_way;
    line_t                       victim_line;

    assign idle      = (st == ST_IDLE);
    assign cpu_ready = idle;
    assign look_addr = cfg_valid ? cfg_addr : cpu_addr;
    assign look_set  = set_of(look_addr);
    assign look_tag  = tag_of(look_addr);
    assign r_set     = set_of(r_addr);
    assign cpu_take  = idle && !cfg_valid && cpu_req;
    assign at_cap    = (lock_cnt == LCNT_W'(LOCK_CAP));

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_valid[w] = lines[look_set][w].valid;
        assign way_lock[w]  = lines[look_set][w].lock;
        assign hit_vec[w]   = lines[look_set][w].valid && lines[look_set][w].tag == look_tag;
        assign way_blk[w]   = {lines[look_set][w].tag, look_set};
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    assign hit = |hit_vec;

    lmc_miss_table #(.N(MT_N), .NQ(WAYS)) u_mt (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (idle && cfg_valid && !cfg_lock),
        .cfg_blk (cfg_addr),
        .cfg_cnt (cfg_count),
        .inc_en  (cpu_take && !hit),
        .inc_blk (cpu_addr),
        .q_blk   (way_blk),
        .q_cnt   (way_cnt)
    );

    assign touch_en  = (cpu_take && hit) || (st == ST_FILL && mem_ack);
    assign touch_set = idle ? look_set : r_set;
    assign touch_way = idle ? hit_way : r_way;

    lmc_lru u_lru (
        .clk       (clk),
        .rst       (rst),
        .rd_set    (look_set),
        .rd_age    (way_age),
        .touch_en  (touch_en),
        .touch_set (touch_set),
        .touch_way (touch_way)
    );

    lmc_victim_sel u_vic (
        .valid (way_valid),
        .lock  (way_lock),
        .cnt   (way_cnt),
        .age   (way_age),
        .found (vic_found),
        .way   (vic_way)
    );

    assign vic_dirty   = lines[look_set][vic_way].valid && lines[look_set][vic_way].dirty;
    assign victim_line = lines[r_set][r_way];

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_addr;
        mem_wdata = r_wdata;
        case (st)
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {victim_line.tag, r_set};
                mem_wdata = victim_line.data;
            end
            ST_FILL: mem_req = 1'b1;
            ST_BYP: begin
                mem_req = 1'b1;
                mem_we  = (r_op == OP_WR);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            r_op      <= OP_RD;
            r_addr    <= '0;
            r_wdata   <= '0;
            r_way     <= '0;
            lock_cnt  <= '0;
            cpu_done  <= 1'b0;
            cfg_done  <= 1'b0;
            cfg_err   <= 1'b0;
            cpu_rdata <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    lines[s][w] <= '0;
        end else begin
            cpu_done <= 1'b0;
            cfg_done <= 1'b0;
            cfg_err  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cfg_valid) begin
                        if (!cfg_lock) begin
                            cfg_done <= 1'b1;
                        end else if (hit) begin
                            if (lines[look_set][hit_way].lock) begin
                                cfg_done <= 1'b1;
                            end else if (at_cap) begin
                                cfg_err <= 1'b1;
                            end else begin
                                lines[look_set][hit_way].lock <= 1'b1;
                                lock_cnt <= lock_cnt + 1'b1;
                                cfg_done <= 1'b1;
                            end
                        end else if (at_cap || !vic_found) begin
                            cfg_err <= 1'b1;
                        end else begin
                            r_op   <= OP_LOCK;
                            r_addr <= cfg_addr;
                            r_way  <= vic_way;
                            st     <= vic_dirty ? ST_WB : ST_FILL;
                        end
                    end else if (cpu_req) begin
                        if (hit) begin
                            if (cpu_we) begin
                                lines[look_set][hit_way].data  <= cpu_wdata;
                                lines[look_set][hit_way].dirty <= 1'b1;
                            end else begin
                                cpu_rdata <= lines[look_set][hit_way].data;
                            end
                            cpu_done <= 1'b1;
                        end else begin
                            r_op    <= cpu_we ? OP_WR : OP_RD;
                            r_addr  <= cpu_addr;
                            r_wdata <= cpu_wdata;
                            r_way   <= vic_way;
                            if (!vic_found)     st <= ST_BYP;
                            else if (vic_dirty) st <= ST_WB;
                            else                st <= ST_FILL;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_ack) st <= ST_FILL;
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        lines[r_set][r_way] <= '{lock:  (r_op == OP_LOCK),
                                                 valid: 1'b1,
                                                 dirty: (r_op == OP_WR),
                                                 tag:   tag_of(r_addr),
                                                 data:  (r_op == OP_WR) ? r_wdata : mem_rdata};
                        if (r_op == OP_LOCK) begin
                            lock_cnt <= lock_cnt + 1'b1;
                            cfg_done <= 1'b1;
                        end else begin
                            if (r_op == OP_RD) cpu_rdata <= mem_rdata;
                            cpu_done <= 1'b1;
                        end
                        st <= ST_IDLE;
                    end
                end
                ST_BYP: begin
                    if (mem_ack) begin
                        if (r_op == OP_RD) cpu_rdata <= mem_rdata;
                        cpu_done <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    logic [LINES-1:0]       lock_vec, valid_vec;
    logic [LINES*TAG_W-1:0] tag_flat;
    for (genvar s = 0; s < SETS; s++) begin : g_fs
        for (genvar w = 0; w < WAYS; w++) begin : g_fw
            assign lock_vec[s*WAYS+w]                   = lines[s][w].lock;
            assign valid_vec[s*WAYS+w]                  = lines[s][w].valid;
            assign tag_flat[(s*WAYS+w)*TAG_W +: TAG_W]  = lines[s][w].tag;
        end
    end
endmodule

// File: rtl/lmc_cache_chk.sv
module lmc_cache_chk
    import lmc_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   cpu_ready,
    input logic                   cpu_done,
    input logic                   cfg_done,
    input logic                   cfg_err,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [DATA_W-1:0]      mem_wdata,
    input logic                   mem_ack,
    input logic [LCNT_W-1:0]      lock_cnt,
    input logic [LINES-1:0]       lock_vec,
    input logic [LINES-1:0]       valid_vec,
    input logic [LINES*TAG_W-1:0] tag_flat
);
    // R9
    lock_cap_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(lock_vec) <= LOCK_CAP && lock_cnt <= LCNT_W'(LOCK_CAP));

    // R9
    lock_count_match_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(lock_vec) == int'(lock_cnt));

    // R7
    for (genvar i = 0; i < LINES; i++) begin : g_lk
        locked_line_kept_chk: assert property (@(posedge clk) disable iff (rst)
            lock_vec[i] |=> lock_vec[i] && valid_vec[i] &&
                            $stable(tag_flat[i*TAG_W +: TAG_W]));
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));

    // R8
    cfg_resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_done && cfg_err));

    // R2
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_done || cfg_done || cfg_err) |-> cpu_ready && !mem_req);
endmodule

bind lmc_cache lmc_cache_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_ready (cpu_ready),
    .cpu_done  (cpu_done),
    .cfg_done  (cfg_done),
    .cfg_err   (cfg_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .lock_cnt  (lock_cnt),
    .lock_vec  (lock_vec),
    .valid_vec (valid_vec),
    .tag_flat  (tag_flat)
);

// File: tb/tb_lmc_cache.sv
module tb_lmc_cache;
    import lmc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 1 << ADDR_W;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              cpu_req, cpu_we;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata;
    logic              cpu_ready, cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cfg_valid, cfg_lock;
    logic [ADDR_W-1:0] cfg_addr;
    logic [CNT_W-1:0]  cfg_count;
    logic              cfg_done, cfg_err;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack;
    logic [DATA_W-1:0] mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmc_cache dut (.*);

    // memory responder and its traffic counters
    logic [DATA_W-1:0] mem [MEM_N];
    int n_rd = 0, n_wr = 0;

    // behavioural reference model
    int m_valid [SETS][WAYS], m_lock [SETS][WAYS], m_dirty [SETS][WAYS];
    int m_tag [SETS][WAYS], m_age [SETS][WAYS];
    logic [DATA_W-1:0] m_data [SETS][WAYS];
    logic [DATA_W-1:0] m_mem [MEM_N];
    int mt_v [MT_N], mt_b [MT_N], mt_c [MT_N];
    int m_lcnt;

    int n_chk = 0, n_fail = 0;
    bit timed_out = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int mcnt(input int blk);
        int e = blk % MT_N;
        return (mt_v[e] != 0 && mt_b[e] == blk) ? mt_c[e] : 0;
    endfunction

    function automatic int pick_victim(input int s);
        int best = -1;
        for (int w = 0; w < WAYS; w++)
            if (m_valid[s][w] == 0) return w;
        for (int w = 0; w < WAYS; w++) begin
            if (m_lock[s][w] == 0) begin
                if (best < 0) best = w;
                else begin
                    int cw = mcnt(m_tag[s][w] * SETS + s);
                    int cb = mcnt(m_tag[s][best] * SETS + s);
                    if (cw < cb || (cw == cb && m_age[s][w] > m_age[s][best])) best = w;
                end
            end
        end
        return best;
    endfunction

    function automatic void m_touch(input int s, input int w);
        int old = m_age[s][w];
        for (int v = 0; v < WAYS; v++)
            if (v != w && m_age[s][v] < old) m_age[s][v]++;
        m_age[s][w] = 0;
    endfunction

    function automatic int find_hit(input int s, input int t);
        for (int w = 0; w < WAYS; w++)
            if (m_valid[s][w] != 0 && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic void m_evict_fill(input int s, input int w, input int addr,
                                         inout int wr);
        if (m_valid[s][w] != 0 && m_dirty[s][w] != 0) begin
            m_mem[m_tag[s][w] * SETS + s] = m_data[s][w];
            wr++;
        end
        m_valid[s][w] = 1;
        m_tag[s][w]   = addr / SETS;
        m_data[s][w]  = m_mem[addr];
        m_dirty[s][w] = 0;
        m_lock[s][w]  = 0;
    endfunction

    task automatic do_cpu(input bit we, input int addr, input logic [DATA_W-1:0] wd,
                          input string req);
        int s = addr % SETS, t = addr / SETS, w, e;
        int ex_rd = 0, ex_wr = 0, cyc = 0, r0, w0;
        logic [DATA_W-1:0] ex_data = '0;
        bit is_hit;
        w = find_hit(s, t);
        is_hit = (w >= 0);
        if (is_hit) begin
            if (we) begin m_data[s][w] = wd; m_dirty[s][w] = 1; end
            else ex_data = m_data[s][w];
            m_touch(s, w);
        end else begin
            w = pick_victim(s);
            e = addr % MT_N;
            if (mt_v[e] != 0 && mt_b[e] == addr) begin
                if (mt_c[e] < CMAX) mt_c[e]++;
            end else begin
                mt_v[e] = 1; mt_b[e] = addr; mt_c[e] = 1;
            end
            if (w < 0) begin
                if (we) begin m_mem[addr] = wd; ex_wr = 1; end
                else begin ex_data = m_mem[addr]; ex_rd = 1; end
            end else begin
                m_evict_fill(s, w, addr, ex_wr);
                ex_rd = 1;
                if (we) begin m_data[s][w] = wd; m_dirty[s][w] = 1; end
                else ex_data = m_data[s][w];
                m_touch(s, w);
            end
        end
        @(negedge clk);
        r0 = n_rd; w0 = n_wr;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        cyc = 1;
        while (!cpu_done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(cpu_done, req, "completion", cpu_done, 1);
        if (!we) chk(cpu_rdata == ex_data, req, $sformatf("rdata @%0d", addr), cpu_rdata, ex_data);
        chk(n_rd - r0 == ex_rd, req, $sformatf("mem reads @%0d", addr), n_rd - r0, ex_rd);
        chk(n_wr - w0 == ex_wr, req, $sformatf("mem writes @%0d", addr), n_wr - w0, ex_wr);
        if (is_hit) chk(cyc == 1, req, "hit latency", cyc, 1);
    endtask

    task automatic do_mt(input int blk, input int cnt, input string req);
        int e = blk % MT_N;
        mt_v[e] = 1; mt_b[e] = blk; mt_c[e] = cnt;
        @(negedge clk);
        cfg_valid = 1'b1; cfg_lock = 1'b0; cfg_addr = ADDR_W'(blk); cfg_count = CNT_W'(cnt);
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(cfg_done && !cfg_err, req, "table write done", cfg_done, 1);
    endtask

    task automatic do_lock(input int addr, input string req);
        int s = addr % SETS, t = addr / SETS, w, cyc = 0, r0, w0;
        int ex_rd = 0, ex_wr = 0;
        bit ex_err = 0;
        w = find_hit(s, t);
        if (w >= 0) begin
            if (m_lock[s][w] == 0) begin
                if (m_lcnt == LOCK_CAP) ex_err = 1;
                else begin m_lock[s][w] = 1; m_lcnt++; end
            end
        end else if (m_lcnt == LOCK_CAP) begin
            ex_err = 1;
        end else begin
            w = pick_victim(s);
            if (w < 0) ex_err = 1;
            else begin
                m_evict_fill(s, w, addr, ex_wr);
                ex_rd = 1;
                m_lock[s][w] = 1;
                m_lcnt++;
                m_touch(s, w);
            end
        end
        @(negedge clk);
        r0 = n_rd; w0 = n_wr;
        cfg_valid = 1'b1; cfg_lock = 1'b1; cfg_addr = ADDR_W'(addr); cfg_count = '0;
        @(negedge clk);
        cfg_valid = 1'b0;
        cyc = 1;
        while (!cfg_done && !cfg_err && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(cfg_err == ex_err, req, $sformatf("lock err @%0d", addr), cfg_err, ex_err);
        chk(cfg_done == !ex_err, req, $sformatf("lock done @%0d", addr), cfg_done, !ex_err);
        chk(n_rd - r0 == ex_rd, req, $sformatf("lock reads @%0d", addr), n_rd - r0, ex_rd);
        chk(n_wr - w0 == ex_wr, req, $sformatf("lock writes @%0d", addr), n_wr - w0, ex_wr);
    endtask

    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                if (mem_we) begin mem[mem_addr] = mem_wdata; n_wr++; end
                else begin mem_rdata = mem[mem_addr]; n_rd++; end
                mem_ack = 1'b1;
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        timed_out = 1;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            mem[i]   = 32'hC0DE_0000 + DATA_W'(i * 7);
            m_mem[i] = mem[i];
        end
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_lock[s][w] = 0; m_dirty[s][w] = 0;
                m_tag[s][w] = 0; m_age[s][w] = w; m_data[s][w] = '0;
            end
        for (int e = 0; e < MT_N; e++) begin mt_v[e] = 0; mt_b[e] = 0; mt_c[e] = 0; end
        m_lcnt = 0;

        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        cfg_valid = 1'b0; cfg_lock = 1'b0; cfg_addr = '0; cfg_count = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cpu_ready, "R1", "cpu_ready", cpu_ready, 1);
        chk(!cpu_done && !cfg_done && !cfg_err, "R1", "pulses low",
            {cpu_done, cfg_done, cfg_err}, 0);
        chk(!mem_req, "R1", "mem_req", mem_req, 0);
        do_cpu(0, 0, '0, "R1");            // must miss
        do_cpu(0, 0, '0, "R2");            // hit
        do_cpu(0, 1, '0, "R3");
        do_cpu(0, 2, '0, "R3");
        do_cpu(0, 3, '0, "R3");
        do_cpu(0, 4, '0, "R3");            // same set as 0, other tag
        do_cpu(0, 0, '0, "R3");            // both resident
        do_cpu(1, 1, 32'h1111_AAAA, "R4"); // write hit, no traffic
        do_cpu(0, 1, '0, "R4");

        // R5 / R6: seeded counts steer the victim in set 1
        do_mt(9, 12, "R5");
        do_mt(13, 12, "R5");
        do_mt(1, 12, "R5");
        do_mt(5, 0, "R5");
        do_cpu(0, 5, '0, "R6");
        do_cpu(0, 9, '0, "R6");
        do_cpu(0, 13, '0, "R6");
        do_cpu(0, 17, '0, "R6");           // lowest count is block 5
        do_cpu(0, 1, '0, "R6");
        do_cpu(0, 5, '0, "R6");

        // R6 ties broken by recency in set 2
        do_cpu(0, 6, '0, "R6");
        do_cpu(0, 10, '0, "R6");
        do_cpu(0, 14, '0, "R6");
        do_cpu(0, 2, '0, "R6");
        do_cpu(0, 18, '0, "R6");
        do_cpu(0, 2, '0, "R6");

        // R8 / R9 locking set 3 completely
        do_lock(3, "R8");
        do_lock(7, "R8");
        do_lock(11, "R8");
        do_lock(15, "R8");
        do_lock(0, "R9");                  // cap reached: refused
        do_lock(40, "R9");                 // absent block: refused
        do_lock(3, "R9");                  // already locked: done
        do_cpu(0, 0, '0, "R9");            // refused lock left line as it was

        // R10 bypass in the fully locked set
        do_cpu(0, 19, '0, "R10");
        do_cpu(0, 19, '0, "R10");
        do_cpu(1, 19, 32'hBEEF_0019, "R10");
        do_cpu(0, 19, '0, "R10");
        do_cpu(1, 23, 32'hBEEF_0023, "R10");

        // R7 locked lines still hit
        do_cpu(0, 3, '0, "R7");
        do_cpu(0, 7, '0, "R7");
        do_cpu(0, 11, '0, "R7");
        do_cpu(0, 15, '0, "R7");

        // R4 dirty eviction in set 0
        do_cpu(1, 8, 32'hD00D_0008, "R4");
        do_cpu(1, 12, 32'hD00D_000C, "R4");
        do_cpu(0, 16, '0, "R4");
        do_cpu(0, 20, '0, "R4");
        do_cpu(0, 24, '0, "R4");
        do_cpu(0, 28, '0, "R4");
        do_cpu(0, 8, '0, "R4");

        // R5 saturation: repeated bypass misses
        for (int k = 0; k < CMAX + 3; k++) do_cpu(0, 27, '0, "R5");

        // mixed traffic against the model
        for (int k = 0; k < 400; k++) begin
            int a = $urandom_range(0, 47);
            int sel = $urandom_range(0, 9);
            if (sel == 0) do_mt(a, $urandom_range(0, CMAX), "R5");
            else if (sel < 4) do_cpu(1, a, $urandom, "R4");
            else do_cpu(0, a, '0, "R6");
        end
        for (int k = 0; k < 4; k++) do_cpu(0, 3 + 4 * k, '0, "R7");

        if (!timed_out) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule